// File: doc/BRIEF.md
# Dual-Ratio Fractional Clock Divider

This block produces a low-rate timebase strobe, nominally 32768 per second, from a fast reference clock such as 24 MHz. No single integer divide gives that rate exactly. The block therefore interleaves two integer periods, a "primary" length and a "secondary" length. It repeats the primary period a programmable number of times and then the secondary period a programmable number of times. The long-run divide ratio is the weighted mean (A·RA + B·RB)/(RA + RB), where A and B are the two lengths and RA and RB are their repeat counts. With lengths 733 and 732 and repeat counts 2 and 3, the mean is 732.4 reference cycles per strobe.

The block is set up through two 32-bit configuration words written over a simple write strobe. Every length and repeat field is stored as its value minus one. The output is a single-cycle enable on the reference clock, and downstream counters use it to advance by one. It needs both an input-gate bit and the correct output-mode code before it produces any strobes.

Top module: `frdiv_top`

## Requirements
- R1: After synchronous reset both configuration words read as zero, so the gate is off, and `tick_o` stays low until the divider is configured.
- R2: Word 0 (`cfg_sel_i`=0) holds the gate enable in bit 31, the output mode in bits 29:28, the primary length field in bits 11:0 and the secondary length field in bits 23:12.
- R3: Word 1 (`cfg_sel_i`=1) holds the primary repeat field in bits 11:0 and the secondary repeat field in bits 23:12.
- R4: A length field holding value v gives a period of v+1 reference cycles, so v=0 gives a strobe every cycle.
- R5: A repeat field holding value r gives r+1 periods. The strobe pattern is (primary repeat + 1) periods of the primary length, then (secondary repeat + 1) periods of the secondary length, over and over. Each strobe is high for exactly one cycle, on the last cycle of its period.
- R6: A write to either word restarts the pattern at the first primary period. The first strobe is high in the cycle that follows the (primary field + 1)-th rising edge after the write edge.
- R7: While the gate bit is 0, no strobe is produced and the counters stay cleared.
- R8: An output mode other than 1 produces no strobes, even with the gate on.
- R9: With length fields 0x2DC and 0x2DB and repeat fields 1 and 2, exactly 5 strobes occur in every 3662 reference cycles, which is a mean divide of 732.4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Selects configuration word 0 or 1 |
| cfg_wdata_i | input | 32 | Configuration write data |
| tick_o | output | 1 | Registered single-cycle timebase strobe |

## Verification
The strobe is registered, so it appears in the cycle after the period counter reaches its terminal value. The first strobe after a configuration write is due just after the (primary+1)-th rising edge that follows the write edge. The bench counts rising edges from the write edge and samples `tick_o` on each following falling edge. It compares each sample with a cycle-by-cycle arithmetic model of the pattern. For the gate and mode cases it checks every cycle for the absence of strobes, and it sweeps small length and repeat values so that each phase boundary falls at a different cycle.

// File: rtl/frdiv_pkg.sv
package frdiv_pkg;
  localparam int REG_W    = 32;
  localparam int GATE_BIT = 31;
  localparam int MODE_LSB = 28;
  localparam logic [1:0] MODE_TICK = 2'd1;
  typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} phase_e;
endpackage

// File: rtl/frdiv_cfg.sv
module frdiv_cfg #(
  parameter int FW = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic                       sel,
  input  logic [frdiv_pkg::REG_W-1:0] wdata,
  output logic                       gate,
  output logic [1:0]                 mode,
  output logic [FW-1:0]              len_a,
  output logic [FW-1:0]              len_b,
  output logic [FW-1:0]              rep_a,
  output logic [FW-1:0]              rep_b
);
  import frdiv_pkg::*;

  // word 0: gate, mode and both lengths
  always_ff @(posedge clk) begin
    if (rst) begin
      gate  <= 1'b0;
      mode  <= 2'd0;
      len_a <= '0;
      len_b <= '0;
    end else if (we && !sel) begin
      gate  <= wdata[GATE_BIT];
      mode  <= wdata[MODE_LSB+1:MODE_LSB];
      len_a <= wdata[FW-1:0];
      len_b <= wdata[2*FW-1:FW];
    end
  end

  // word 1: both repeat counts
  always_ff @(posedge clk) begin
    if (rst) begin
      rep_a <= '0;
      rep_b <= '0;
    end else if (we && sel) begin
      rep_a <= wdata[FW-1:0];
      rep_b <= wdata[2*FW-1:FW];
    end
  end
endmodule

// File: rtl/frdiv_period.sv
module frdiv_period #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt <= '0;
    else if (wrap)          cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/frdiv_seq.sv
module frdiv_seq #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  input  logic         adv,
  input  logic [W-1:0] len_a,
  input  logic [W-1:0] len_b,
  input  logic [W-1:0] rep_a,
  input  logic [W-1:0] rep_b,
  output logic [W-1:0] cur_len,
  output logic [W-1:0] cur_rep,
  output logic [W-1:0] rep
);
  import frdiv_pkg::*;

  phase_e phase;

  assign cur_len = (phase == PH_B) ? len_b : len_a;
  assign cur_rep = (phase == PH_B) ? rep_b : rep_a;

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      phase <= PH_A;
      rep   <= '0;
    end else if (adv) begin
      if (rep == cur_rep) begin
        rep   <= '0;
        phase <= (phase == PH_A) ? PH_B : PH_A;
      end else begin
        rep <= rep + 1'b1;
      end
    end
  end
endmodule

// File: rtl/frdiv_top.sv
module frdiv_top #(
  parameter int FIELD_W = 12
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        cfg_we_i,
  input  logic        cfg_sel_i,
  input  logic [31:0] cfg_wdata_i,
  output logic        tick_o
);
  import frdiv_pkg::*;

  logic               gate_w;
  logic [1:0]         mode_w;
  logic [FIELD_W-1:0] len_a_w, len_b_w, rep_a_w, rep_b_w;
  logic [FIELD_W-1:0] len_w, rep_lim_w, rep_w, cnt_w;
  logic               wrap_w;
  logic               run_w;

  frdiv_cfg #(.FW(FIELD_W)) u_cfg (
    .clk(clk_i), .rst(rst_i), .we(cfg_we_i), .sel(cfg_sel_i), .wdata(cfg_wdata_i),
    .gate(gate_w), .mode(mode_w),
    .len_a(len_a_w), .len_b(len_b_w), .rep_a(rep_a_w), .rep_b(rep_b_w)
  );

  assign run_w = gate_w && (mode_w == MODE_TICK);

  frdiv_period #(.W(FIELD_W)) u_period (
    .clk(clk_i), .rst(rst_i), .clr(cfg_we_i), .run(run_w),
    .lim(len_w), .cnt(cnt_w), .wrap(wrap_w)
  );

  frdiv_seq #(.W(FIELD_W)) u_seq (
    .clk(clk_i), .rst(rst_i), .clr(cfg_we_i), .run(run_w), .adv(wrap_w),
    .len_a(len_a_w), .len_b(len_b_w), .rep_a(rep_a_w), .rep_b(rep_b_w),
    .cur_len(len_w), .cur_rep(rep_lim_w), .rep(rep_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i || cfg_we_i) tick_o <= 1'b0;
    else                   tick_o <= wrap_w;
  end
endmodule

// File: rtl/frdiv_chk.sv
module frdiv_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_we,
  input logic         tick,
  input logic         gate,
  input logic [1:0]   mode,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cur_len,
  input logic [W-1:0] rep,
  input logic [W-1:0] cur_rep
);
  import frdiv_pkg::*;

  assert_restart_clear_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (!tick && cnt == '0 && rep == '0));

  assert_gate_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !gate |=> !tick);

  assert_mode_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_TICK) |=> !tick);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= cur_len);

  assert_rep_bound_R5: assert property (@(posedge clk) disable iff (rst)
    rep <= cur_rep);
endmodule

bind frdiv_top frdiv_chk #(.W(FIELD_W)) u_chk (
  .clk(clk_i), .rst(rst_i), .cfg_we(cfg_we_i), .tick(tick_o),
  .gate(gate_w), .mode(mode_w), .cnt(cnt_w), .cur_len(len_w),
  .rep(rep_w), .cur_rep(rep_lim_w)
);

// File: tb/tb_frdiv_top.sv
module tb_frdiv_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we  = 1'b0;
  logic        sel = 1'b0;
  logic [31:0] wdata = '0;
  logic        tick;

  int checks = 0;
  int fails  = 0;

  frdiv_top dut (
    .clk_i(clk), .rst_i(rst), .cfg_we_i(we), .cfg_sel_i(sel),
    .cfg_wdata_i(wdata), .tick_o(tick)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // after return the write edge has passed and we sit on the next falling edge
  task automatic wr(input bit s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [31:0] word0(bit g, logic [1:0] m, int a, int b);
    return {g, 1'b0, m, 4'h0, b[11:0], a[11:0]};
  endfunction

  function automatic logic [31:0] word1(int ra, int rb);
    return {8'h00, rb[11:0], ra[11:0]};
  endfunction

  // model of the strobe pattern, run from the write edge for n cycles
  task automatic expect_pattern(input int a, input int b, input int ra, input int rb,
                                input int n, input string req, output int seen);
    int due = a + 1;
    int ph = 0;
    int rp = 0;
    seen = 0;
    for (int k = 1; k <= n; k++) begin
      bit exp;
      @(negedge clk);
      exp = (k == due);
      if (tick) seen++;
      check(tick == exp, req, int'(tick), int'(exp));
      if (exp) begin
        if (rp == (ph ? rb : ra)) begin rp = 0; ph = 1 - ph; end
        else rp++;
        due += (ph ? b : a) + 1;
      end
    end
  endtask

  task automatic expect_quiet(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(tick == 1'b0, req, int'(tick), 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1 in reset", int'(tick), 0);
    rst = 1'b0;
    expect_quiet(30, "R1 after reset");

    // nominal 32768-per-second setting
    wr(1'b1, word1(1, 2));
    wr(1'b0, word0(1'b1, 2'd1, 'h2DC, 'h2DB));
    expect_pattern('h2DC, 'h2DB, 1, 2, 2 * 3662, "R5 nominal", seen);
    check(seen == 10, "R9 strobes in two patterns", seen, 10);

    // sweep of small lengths and repeats
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int ra = 0; ra < 3; ra++)
          for (int rb = 0; rb < 3; rb++) begin
            wr(1'b1, word1(ra, rb));
            wr(1'b0, word0(1'b1, 2'd1, a, b));
            expect_pattern(a, b, ra, rb, 50, "R2 R3 R4 R5 sweep", seen);
          end

    // restart in the middle of a primary period, then mid secondary
    wr(1'b1, word1(0, 0));
    wr(1'b0, word0(1'b1, 2'd1, 5, 9));
    repeat (3) @(negedge clk);
    wr(1'b1, word1(0, 0));
    expect_pattern(5, 9, 0, 0, 10, "R6 restart word1", seen);
    wr(1'b0, word0(1'b1, 2'd1, 5, 9));
    expect_pattern(5, 9, 0, 0, 40, "R6 restart word0", seen);

    // gate off
    wr(1'b0, word0(1'b0, 2'd1, 2, 2));
    expect_quiet(100, "R7 gate off");
    wr(1'b0, word0(1'b1, 2'd1, 2, 3));
    expect_pattern(2, 3, 0, 0, 30, "R7 gate on again", seen);

    // other output modes
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      wr(1'b0, word0(1'b1, m[1:0], 1, 1));
      expect_quiet(50, "R8 mode off");
    end
    wr(1'b0, word0(1'b1, 2'd1, 1, 1));
    expect_pattern(1, 1, 0, 0, 20, "R8 mode on", seen);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule